// File: doc/BRIEF.md
# Dual-Style Host Bus Interface

This block sits between an 8-bit host processor and the rest of a display controller. A strap input sets the bus style. In strobe style the host marks each transfer with separate active-low read and write strobes. In enable style it uses an active-high enable clock together with a read/write direction level. Both styles share an active-low chip select, a register-select line and an 8-bit data bus. The bidirectional bus is split into an input, an output and an output enable, so the pad ring can build the tristate buffer.

All host inputs are resynchronised into the controller clock. A transfer counts as accepted when its qualifier ends, that is, on the trailing edge of the strobe. Each accepted write gives the core a single-cycle pulse together with the captured byte. The register-select value decides whether that pulse is a command write or a parameter write. Reads are served straight from the pins. With register select low, the host reads a status byte whose top bit reports busy. With register select high, it reads a data byte, and the core gets a pulse when that read ends so it can advance.

Top module: `host_bus_if`

## Requirements
- R1: While reset is asserted, `cmd_wr_o`, `par_wr_o` and `data_rd_o` are low and `wdata_o` is zero.
- R2: In strobe style (`mode_sel_i`=0), a write is qualified while `cs_n_i` and `wr_n_i` are both low. When it ends it gives exactly one pulse, one clock cycle wide. That pulse is on `cmd_wr_o` if `rs_i` was 1 and on `par_wr_o` if `rs_i` was 0, and `wdata_o` carries the byte.
- R3: In enable style (`mode_sel_i`=1), a write is qualified while `cs_n_i` is low, the enable on `rd_n_i` is high and the direction on `wr_n_i` is low (0 = write, 1 = read). It is decoded as in R2.
- R4: With `cs_n_i` high, strobe activity gives no pulse and `hd_oe_o` stays low.
- R5: `hd_oe_o` is high only during a qualified read. In strobe style that is `cs_n_i` low and `rd_n_i` low. In enable style it is `cs_n_i` low, `rd_n_i` (enable) high and `wr_n_i` (direction) high. It is never high during a write.
- R6: During a read with `rs_i`=0, `hd_o` equals {`busy_i`, `status_i`}, so bit 7 is the busy flag.
- R7: During a read with `rs_i`=1, `hd_o` equals `rdata_i`, and one single-cycle `data_rd_o` pulse follows the end of that read. A status read gives no pulse. At most one of the three pulse outputs is high in any cycle.
- R8: No pulse is produced while the qualifier is still held, however long it lasts.
- R9: The captured byte is the one present during the qualifier. A bus change at the moment the strobe is released is ignored. `wdata_o` changes only in a cycle carrying a write pulse.
- R10: In enable style with the enable low, changes on chip select, direction, register select and data give no pulse and no output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 1 | Bus style strap: 0 strobe pair, 1 enable plus direction |
| cs_n_i | input | 1 | Active-low chip select |
| rs_i | input | 1 | Register select: write 1 command / 0 parameter; read 1 data / 0 status |
| rd_n_i | input | 1 | Read strobe (strobe style) or enable clock, active high (enable style) |
| wr_n_i | input | 1 | Write strobe (strobe style) or direction, 1 read (enable style) |
| hd_i | input | 8 | Host data bus, inbound |
| hd_o | output | 8 | Host data bus, outbound |
| hd_oe_o | output | 1 | Output enable for the host data bus |
| busy_i | input | 1 | Core busy flag, shown in status bit 7 |
| status_i | input | 7 | Remaining status bits 6..0 |
| rdata_i | input | 8 | Data byte offered for data reads |
| cmd_wr_o | output | 1 | One-cycle command write pulse |
| par_wr_o | output | 1 | One-cycle parameter write pulse |
| wdata_o | output | 8 | Byte captured by the last write |
| data_rd_o | output | 1 | One-cycle pulse after a data read ends |

## Verification
The embedded properties watch, on every cycle, that pulses are one cycle wide and mutually exclusive, and that the write byte moves only together with a write pulse. They also check that no write pulse appears while a strobe-style write strobe has been held low for several cycles. The rules that only the directed scenarios can show are the ones that depend on the whole transfer. These are the command-versus-parameter decode in each bus style, the exact count of one pulse per transfer, the capture of the byte seen before the release, the content of the status and data bytes, and the absence of any effect from a deselected or enable-low bus.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

   typedef enum logic {
      STYLE_STROBE = 1'b0,
      STYLE_ENABLE = 1'b1
   } bus_style_e;

   typedef struct packed {
      logic cs_n;
      logic rs;
      logic rdp;
      logic wrp;
   } ctl_pins_t;

   localparam int CTL_W = $bits(ctl_pins_t);

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hbi_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hbi_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hbi_qual.sv
module hbi_qual
   import hbi_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_style_e        style_i,
   input  ctl_pins_t         ctl_s_i,
   input  logic [DATA_W-1:0] data_s_i,
   output logic              cmd_wr_o,
   output logic              par_wr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              data_rd_o
);

   logic              wr_act, rd_act;
   logic              wr_act_q, rd_act_q;
   logic              cap_rs_q;
   logic [DATA_W-1:0] cap_data_q;
   logic              wr_end, rd_end;

   always_comb begin
      wr_act = 1'b0;
      rd_act = 1'b0;
      unique case (style_i)
         STYLE_ENABLE: begin
            wr_act = !ctl_s_i.cs_n && ctl_s_i.rdp && !ctl_s_i.wrp;
            rd_act = !ctl_s_i.cs_n && ctl_s_i.rdp &&  ctl_s_i.wrp;
         end
         default: begin
            wr_act = !ctl_s_i.cs_n && !ctl_s_i.wrp;
            rd_act = !ctl_s_i.cs_n && !ctl_s_i.rdp && ctl_s_i.wrp;
         end
      endcase
   end

   assign wr_end = wr_act_q && !wr_act;
   assign rd_end = rd_act_q && !rd_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q   <= 1'b0;
         rd_act_q   <= 1'b0;
         cap_rs_q   <= 1'b0;
         cap_data_q <= '0;
      end else begin
         wr_act_q <= wr_act;
         rd_act_q <= rd_act;
         if (wr_act || rd_act) begin
            cap_rs_q <= ctl_s_i.rs;
         end
         if (wr_act) begin
            cap_data_q <= data_s_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_wr_o  <= 1'b0;
         par_wr_o  <= 1'b0;
         data_rd_o <= 1'b0;
         wdata_o   <= '0;
      end else begin
         cmd_wr_o  <= wr_end &&  cap_rs_q;
         par_wr_o  <= wr_end && !cap_rs_q;
         data_rd_o <= rd_end &&  cap_rs_q;
         if (wr_end) begin
            wdata_o <= cap_data_q;
         end
      end
   end

   // R2
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_o || par_wr_o || data_rd_o) |=> !(cmd_wr_o || par_wr_o || data_rd_o));

   // R7
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_wr_o, par_wr_o, data_rd_o}));

   // R9
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wdata_o) |-> (cmd_wr_o || par_wr_o));

endmodule

// File: rtl/hbi_rdmux.sv
module hbi_rdmux
   import hbi_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit GATE_DATA = 1'b1,
   localparam int STAT_W   = DATA_W - 1
) (
   input  bus_style_e        style_i,
   input  logic              cs_n_i,
   input  logic              rs_i,
   input  logic              rdp_i,
   input  logic              wrp_i,
   input  logic              busy_i,
   input  logic [STAT_W-1:0] status_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [DATA_W-1:0] hd_o,
   output logic              hd_oe_o
);

   logic [DATA_W-1:0] sel_byte;

   always_comb begin
      unique case (style_i)
         STYLE_ENABLE: hd_oe_o = !cs_n_i && rdp_i && wrp_i;
         default:      hd_oe_o = !cs_n_i && !rdp_i && wrp_i;
      endcase
   end

   assign sel_byte = rs_i ? rdata_i : {busy_i, status_i};

   if (GATE_DATA) begin : g_gated
      assign hd_o = hd_oe_o ? sel_byte : '0;
   end else begin : g_open
      assign hd_o = sel_byte;
   end

endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
   import hbi_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit GATE_DATA   = 1'b1,
   localparam int STAT_W     = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_sel_i,
   input  logic              cs_n_i,
   input  logic              rs_i,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   input  logic [DATA_W-1:0] hd_i,
   output logic [DATA_W-1:0] hd_o,
   output logic              hd_oe_o,
   input  logic              busy_i,
   input  logic [STAT_W-1:0] status_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              cmd_wr_o,
   output logic              par_wr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              data_rd_o
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("host_bus_if: DATA_W must be at least 2");
   end

   localparam int                  SYN_W   = CTL_W + DATA_W;
   localparam ctl_pins_t           CTL_IDLE = '{cs_n: 1'b1, rs: 1'b0, rdp: 1'b1, wrp: 1'b1};
   localparam logic [SYN_W-1:0]    SYN_RST = {CTL_IDLE, {DATA_W{1'b0}}};

   bus_style_e        style;
   ctl_pins_t         ctl_raw, ctl_s;
   logic [DATA_W-1:0] data_s;
   logic [SYN_W-1:0]  syn_q;

   assign style   = bus_style_e'(mode_sel_i);
   assign ctl_raw = '{cs_n: cs_n_i, rs: rs_i, rdp: rd_n_i, wrp: wr_n_i};

   hbi_sync #(
      .W       (SYN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYN_RST)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ctl_raw, hd_i}),
      .q_o   (syn_q)
   );

   assign ctl_s  = ctl_pins_t'(syn_q[SYN_W-1:DATA_W]);
   assign data_s = syn_q[DATA_W-1:0];

   hbi_qual #(
      .DATA_W (DATA_W)
   ) qual_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .style_i   (style),
      .ctl_s_i   (ctl_s),
      .data_s_i  (data_s),
      .cmd_wr_o  (cmd_wr_o),
      .par_wr_o  (par_wr_o),
      .wdata_o   (wdata_o),
      .data_rd_o (data_rd_o)
   );

   hbi_rdmux #(
      .DATA_W    (DATA_W),
      .GATE_DATA (GATE_DATA)
   ) rdmux_i (
      .style_i  (style),
      .cs_n_i   (cs_n_i),
      .rs_i     (rs_i),
      .rdp_i    (rd_n_i),
      .wrp_i    (wr_n_i),
      .busy_i   (busy_i),
      .status_i (status_i),
      .rdata_i  (rdata_i),
      .hd_o     (hd_o),
      .hd_oe_o  (hd_oe_o)
   );

   // R8
   no_early_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_sel_i && !cs_n_i && !wr_n_i && $past(!wr_n_i) && $past(!wr_n_i, 2)
       && $past(!wr_n_i, 3) && $past(!cs_n_i, 3))
      |-> !(cmd_wr_o || par_wr_o));

   // R5
   oe_not_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel_i && !wr_n_i) |-> !hd_oe_o);

endmodule

// File: tb/host_bus_if_tb_top.sv
module host_bus_if_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_sel = 1'b0;
   logic       cs_n = 1'b1;
   logic       rs = 1'b0;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] hd_i = 8'h00;
   logic [7:0] hd_o;
   logic       hd_oe;
   logic       busy = 1'b0;
   logic [6:0] status = 7'h00;
   logic [7:0] rdata = 8'h00;
   logic       cmd_wr, par_wr, data_rd;
   logic [7:0] wdata;

   int n_chk = 0;
   int n_bad = 0;
   int cmd_cnt = 0, par_cnt = 0, rd_cnt = 0, run = 0;
   bit wide_seen = 1'b0;
   bit done = 1'b0;
   logic [7:0] last_w = 8'h00;

   always #(CLK_PERIOD / 2) clk = ~clk;

   host_bus_if dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_sel_i (mode_sel),
      .cs_n_i     (cs_n),
      .rs_i       (rs),
      .rd_n_i     (rd_n),
      .wr_n_i     (wr_n),
      .hd_i       (hd_i),
      .hd_o       (hd_o),
      .hd_oe_o    (hd_oe),
      .busy_i     (busy),
      .status_i   (status),
      .rdata_i    (rdata),
      .cmd_wr_o   (cmd_wr),
      .par_wr_o   (par_wr),
      .wdata_o    (wdata),
      .data_rd_o  (data_rd)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_wr) begin cmd_cnt++; last_w = wdata; end
         if (par_wr) begin par_cnt++; last_w = wdata; end
         if (data_rd) rd_cnt++;
         if (cmd_wr || par_wr || data_rd) begin
            run++;
            if (run > 1) wide_seen = 1'b1;
         end else begin
            run = 0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle_bus();
      cs_n = 1'b1;
      wr_n = 1'b1;
      rd_n = mode_sel ? 1'b0 : 1'b1;
   endtask

   task automatic set_style(input logic m);
      @(negedge clk);
      mode_sel = m;
      idle_bus();
      repeat (6) @(negedge clk);
   endtask

   // drive a write; the bus byte flips at release to probe R9
   task automatic do_write(input logic is_cmd, input logic [7:0] b, input int hold);
      @(negedge clk);
      cs_n = 1'b0; rs = is_cmd; hd_i = b;
      if (mode_sel) begin wr_n = 1'b0; rd_n = 1'b1; end
      else          begin wr_n = 1'b0; end
      repeat (hold) @(negedge clk);
      check(hd_oe == 1'b0, "R5 oe during write", hd_oe, 0);
      if (mode_sel) rd_n = 1'b0; else wr_n = 1'b1;
      hd_i = ~b;
      @(negedge clk);
      idle_bus();
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check({cmd_wr, par_wr, data_rd} == 3'b000, "R1 pulses in reset", {cmd_wr, par_wr, data_rd}, 0);
      check(wdata == 8'h00, "R1 wdata in reset", wdata, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_write(input logic is_cmd, input logic [7:0] b, input string req);
      int c0 = cmd_cnt, p0 = par_cnt;
      do_write(is_cmd, b, 4);
      check(cmd_cnt == c0 + (is_cmd ? 1 : 0), {req, " cmd pulses"}, cmd_cnt - c0, is_cmd ? 1 : 0);
      check(par_cnt == p0 + (is_cmd ? 0 : 1), {req, " par pulses"}, par_cnt - p0, is_cmd ? 0 : 1);
      // R9 byte from before the release
      check(last_w == b, {req, " R9 wdata"}, last_w, b);
      check(wdata == b, {req, " R9 wdata held"}, wdata, b);
   endtask

   task automatic t_deselect();
      int c0 = cmd_cnt + par_cnt + rd_cnt;
      bit oe_seen = 1'b0;
      @(negedge clk);
      cs_n = 1'b1; rs = 1'b1; hd_i = 8'h77;
      wr_n = 1'b0; repeat (4) @(negedge clk); wr_n = 1'b1;
      rd_n = 1'b0;
      repeat (4) begin @(negedge clk); if (hd_oe) oe_seen = 1'b1; end
      rd_n = 1'b1;
      repeat (6) @(negedge clk);
      check(cmd_cnt + par_cnt + rd_cnt == c0, "R4 no pulse deselected", cmd_cnt + par_cnt + rd_cnt - c0, 0);
      check(!oe_seen, "R4 no oe deselected", oe_seen, 0);
      check(wdata == 8'h3C, "R4 wdata untouched", wdata, 8'h3C);
   endtask

   task automatic t_read(input logic sel, input logic [7:0] exp, input string req);
      int r0 = rd_cnt;
      @(negedge clk);
      cs_n = 1'b0; rs = sel;
      if (mode_sel) begin wr_n = 1'b1; rd_n = 1'b1; end
      else          begin rd_n = 1'b0; end
      repeat (3) @(negedge clk);
      check(hd_oe == 1'b1, {req, " R5 oe in read"}, hd_oe, 1);
      check(hd_o == exp, {req, " read byte"}, hd_o, exp);
      if (mode_sel) rd_n = 1'b0; else rd_n = 1'b1;
      #1;
      check(hd_oe == 1'b0, {req, " R5 oe after read"}, hd_oe, 0);
      @(negedge clk);
      idle_bus();
      repeat (6) @(negedge clk);
      check(rd_cnt == r0 + (sel ? 1 : 0), {req, " R7 read pulses"}, rd_cnt - r0, sel ? 1 : 0);
   endtask

   task automatic t_long_hold();
      int c0 = cmd_cnt;
      @(negedge clk);
      cs_n = 1'b0; rs = 1'b1; hd_i = 8'hE1; wr_n = 1'b0;
      repeat (12) @(negedge clk);
      check(cmd_cnt == c0, "R8 no pulse while held", cmd_cnt - c0, 0);
      wr_n = 1'b1;
      @(negedge clk); idle_bus();
      repeat (6) @(negedge clk);
      check(cmd_cnt == c0 + 1, "R8 one pulse after release", cmd_cnt - c0, 1);
      check(last_w == 8'hE1, "R8 byte", last_w, 8'hE1);
   endtask

   task automatic t_enable_low();
      int c0 = cmd_cnt + par_cnt + rd_cnt;
      bit oe_seen = 1'b0;
      @(negedge clk);
      rd_n = 1'b0;
      for (int i = 0; i < 6; i++) begin
         cs_n = i[0]; wr_n = i[1]; rs = i[2]; hd_i = 8'(i * 37);
         repeat (2) begin @(negedge clk); if (hd_oe) oe_seen = 1'b1; end
      end
      idle_bus();
      repeat (6) @(negedge clk);
      check(cmd_cnt + par_cnt + rd_cnt == c0, "R10 no pulse enable low", cmd_cnt + par_cnt + rd_cnt - c0, 0);
      check(!oe_seen, "R10 no oe enable low", oe_seen, 0);
   endtask

   initial begin
      t_reset();
      set_style(1'b0);
      t_write(1'b1, 8'hA5, "R2 strobe cmd");
      t_write(1'b0, 8'h3C, "R2 strobe param");
      t_deselect();
      busy = 1'b1; status = 7'h2A;
      t_read(1'b0, 8'hAA, "R6 strobe status busy");
      busy = 1'b0;
      t_read(1'b0, 8'h2A, "R6 strobe status idle");
      rdata = 8'h5C;
      t_read(1'b1, 8'h5C, "R7 strobe data");
      t_long_hold();
      set_style(1'b1);
      t_write(1'b1, 8'h81, "R3 enable cmd");
      t_write(1'b0, 8'h7E, "R3 enable param");
      busy = 1'b1; status = 7'h05;
      t_read(1'b0, 8'h85, "R6 enable status");
      rdata = 8'hC3;
      t_read(1'b1, 8'hC3, "R7 enable data");
      t_enable_low();
      check(!wide_seen, "R2 pulse width", wide_seen, 0);
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule